// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block queues 32-bit words written by a host and sends them one after another as return-to-zero serial bit cells on two complementary digital rails. A queue of `DEPTH` words (32 by default) takes a write on any cycle in which `wr_en` is high and the queue still has room. While `tx_enable` is high, the block takes the oldest word from the queue and sends it least significant bit first. Each bit is a data half, in which exactly one rail is high, followed by a null half, in which both rails are low. A fixed quiet gap follows each word before the next one starts.

All timing is counted in clock cycles. The half-cell length and the gap length each have one parameter for high speed and one for low speed, and the static `high_speed` input picks between them. Two static inputs control the 32nd bit. It can carry plain data, or it can carry a parity bit that gives the whole word odd or even parity. The `tx_ready` output goes high once every queued word has been sent. `queue_full` reports that further writes will be dropped. Reset is asynchronous and active low. It ends any word in progress at once and empties the queue. The control inputs are ports, so reset does not change them.

Top module: `a429_tx`

## Requirements
- R1: After reset the queue is empty, both rails are low, `tx_ready` is 1 and `queue_full` is 0.
- R2: Bits go out least significant first. A 1 drives `line_pos` high and a 0 drives `line_neg` high for the data half of the cell. Both rails are low in the null half and in the word gap, and the two rails are never high together.
- R3: With `high_speed`=1, each data half and each null half lasts HI_HALF clocks. When a word follows another without a pause, the rails stay low for HI_HALF+HI_GAP clocks after the data half of bit 32.
- R4: With `high_speed`=0, each half lasts LO_HALF clocks. The low time between back-to-back words is LO_HALF+LO_GAP clocks.
- R5: With `parity_on`=0, all 32 bits of the written word are sent unchanged.
- R6: With `parity_on`=1 and `parity_even`=0, bit 32 is replaced so that the 32 sent bits contain an odd number of ones. Bits 1 to 31 are sent unchanged.
- R7: With `parity_on`=1 and `parity_even`=1, bit 32 is replaced so that the 32 sent bits contain an even number of ones.
- R8: The queue holds DEPTH words and sends them in write order. `queue_full` is 1 exactly when DEPTH words are held, and a write attempted while full is dropped.
- R9: When the block is idle, the data half of bit 1 begins on the clock edge that first samples `tx_enable` high with a non-empty queue. It is visible one clock after `tx_enable` is raised.
- R10: `tx_ready` is 0 while the queue holds a word or a word is in its bit cells. It is 1 once the queue is empty and the last word has finished its bits.
- R11: Dropping `tx_enable` in the middle of a word lets that word finish. No further word is taken until `tx_enable` rises again.
- R12: Reset asserted in the middle of a word forces both rails low at once, and the words still in the queue are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that all bit timing counts |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 32 | Word to queue |
| tx_enable | input | 1 | Allows words to be taken from the queue |
| high_speed | input | 1 | Static speed select (1 = high speed) |
| parity_on | input | 1 | Static: bit 32 carries parity when 1 |
| parity_even | input | 1 | Static parity sense (1 = even, 0 = odd) |
| line_pos | output | 1 | Positive rail, high during the data half of a 1 |
| line_neg | output | 1 | Negative rail, high during the data half of a 0 |
| tx_ready | output | 1 | Queue empty and no word in progress |
| queue_full | output | 1 | Queue holds DEPTH words |

## Verification
The bench builds the block with DEPTH=4, HI_HALF=2, HI_GAP=6, LO_HALF=3 and LO_GAP=9. With these values every combination of speed and parity mode can be swept, and each sweep fills the queue completely and drains it back to back. Short half-cells and a short queue make the overflow, gap-length and mid-word enable and reset cases take only a few hundred clocks. A line decoder in the bench measures every half-cell and gap length and rebuilds each word. It compares them with lengths and parity values computed arithmetically.

// File: rtl/a429_tx.sv
module a429_tx #(
  parameter int DEPTH   = 32,
  parameter int HI_HALF = 5,
  parameter int HI_GAP  = 40,
  parameter int LO_HALF = 40,
  parameter int LO_GAP  = 320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        tx_enable,
  input  logic        high_speed,
  input  logic        parity_on,
  input  logic        parity_even,
  output logic        line_pos,
  output logic        line_neg,
  output logic        tx_ready,
  output logic        queue_full
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TM1  = (HI_HALF > HI_GAP) ? HI_HALF : HI_GAP;
  localparam int TM2  = (LO_HALF > LO_GAP) ? LO_HALF : LO_GAP;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_NULL, S_GAP} st_t;

  st_t            st;
  logic [CW-1:0]  tmr;
  logic [4:0]     bit_idx;
  logic [31:0]    word_q;
  logic [31:0]    mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [AW:0]    q_count;

  wire [CW-1:0] half_m1 = high_speed ? CW'(HI_HALF - 1) : CW'(LO_HALF - 1);
  wire [CW-1:0] gap_m1  = high_speed ? CW'(HI_GAP - 1)  : CW'(LO_GAP - 1);

  wire q_empty = (q_count == '0);
  wire push    = wr_en && (q_count != (AW+1)'(DEPTH));
  wire at_edge = (st == S_IDLE) || (st == S_GAP && tmr == '0);
  wire fetch   = tx_enable && !q_empty && at_edge;
  wire in_idle = (st == S_IDLE);

  wire par_bit = (^word_q[30:0]) ^ ~parity_even;
  wire cur_bit = (parity_on && bit_idx == 5'd31) ? par_bit : word_q[bit_idx];

  assign line_pos   = (st == S_DATA) && cur_bit;
  assign line_neg   = (st == S_DATA) && !cur_bit;
  assign tx_ready   = q_empty && (st == S_IDLE || st == S_GAP);
  assign queue_full = (q_count == (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      q_count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (fetch) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !fetch)      q_count <= q_count + 1'b1;
      else if (fetch && !push) q_count <= q_count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tmr     <= '0;
      bit_idx <= '0;
      word_q  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (fetch) begin
          word_q  <= mem[rp];
          bit_idx <= '0;
          tmr     <= half_m1;
          st      <= S_DATA;
        end
        S_DATA: if (tmr == '0) begin
          tmr <= half_m1;
          st  <= S_NULL;
        end else tmr <= tmr - 1'b1;
        S_NULL: if (tmr == '0) begin
          if (bit_idx == 5'd31) begin
            tmr <= gap_m1;
            st  <= S_GAP;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            tmr     <= half_m1;
            st      <= S_DATA;
          end
        end else tmr <= tmr - 1'b1;
        S_GAP: if (tmr == '0) begin
          if (fetch) begin
            word_q  <= mem[rp];
            bit_idx <= '0;
            tmr     <= half_m1;
            st      <= S_DATA;
          end else st <= S_IDLE;
        end else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk #(
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        tx_enable,
  input logic        line_pos,
  input logic        line_neg,
  input logic        tx_ready,
  input logic        queue_full,
  input logic        in_idle,
  input logic [AW:0] q_count
);
  assert_rails_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_pos && line_neg));

  assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!line_pos && !line_neg && q_count == '0));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= (AW+1)'(DEPTH));

  assert_full_drops_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (queue_full && wr_en) |=> (q_count <= $past(q_count)));

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !tx_enable) |=> (!line_pos && !line_neg));

  always_comb begin
    if (!rst_n) assert_reset_quiet_R12: assert (!line_pos && !line_neg);
  end
endmodule

bind a429_tx a429_tx_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tx_enable(tx_enable),
  .line_pos(line_pos), .line_neg(line_neg), .tx_ready(tx_ready),
  .queue_full(queue_full), .in_idle(in_idle), .q_count(q_count)
);

// File: tb/a429_tx_bench.sv
module a429_tx_bench;
  localparam int DEPTH = 4, HI_HALF = 2, HI_GAP = 6, LO_HALF = 3, LO_GAP = 9;

  logic clk = 0, rst_n = 0, wr_en = 0, tx_enable = 0;
  logic high_speed = 1, parity_on = 0, parity_even = 0;
  logic [31:0] wr_data = '0;
  logic line_pos, line_neg, tx_ready, queue_full;

  always #10 clk = ~clk;

  a429_tx #(.DEPTH(DEPTH), .HI_HALF(HI_HALF), .HI_GAP(HI_GAP),
            .LO_HALF(LO_HALF), .LO_GAP(LO_GAP)) u_a429_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tx_enable(tx_enable), .high_speed(high_speed), .parity_on(parity_on),
    .parity_even(parity_even), .line_pos(line_pos), .line_neg(line_neg),
    .tx_ready(tx_ready), .queue_full(queue_full));

  int checks = 0, fails = 0;
  logic [31:0] rx [64];
  int rx_n = 0, bits = 0, act_run = 0, null_run = 0, last_gap = 0;
  int tim_err = 0, rail_err = 0;
  logic prev_act = 0, cur_bit = 0;
  logic [31:0] wbuf = '0;
  int half;
  assign half = high_speed ? HI_HALF : LO_HALF;

  always @(negedge clk) begin
    if (!rst_n) begin
      bits = 0; act_run = 0; null_run = 0; prev_act = 0;
    end else begin
      if (line_pos && line_neg) rail_err++;
      if (line_pos || line_neg) begin
        if (!prev_act) begin
          if (bits != 0 && null_run != half) tim_err++;
          if (bits == 0) last_gap = null_run;
          act_run = 1; cur_bit = line_pos;
        end else act_run++;
        prev_act = 1;
      end else begin
        if (prev_act) begin
          if (act_run != half) tim_err++;
          wbuf[bits] = cur_bit;
          bits++;
          if (bits == 32) begin
            if (rx_n < 64) rx[rx_n] = wbuf;
            rx_n++; bits = 0;
          end
          null_run = 1;
        end else null_run++;
        prev_act = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(logic [31:0] w, logic pon, logic pev);
    logic p;
    if (!pon) return w;
    p = ($countones(w[30:0]) % 2 == 0) ? !pev : pev;
    return {p, w[30:0]};
  endfunction

  task automatic push_word(input logic [31:0] w);
    @(negedge clk); wr_en = 1; wr_data = w;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_rx(input int n);
    int t = 0;
    while (rx_n < n && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(negedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] pat [4];
    int base, lat;
    repeat (3) @(negedge clk);
    chk(!line_pos && !line_neg, "R1", "rails in reset", {line_pos, line_neg}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(tx_ready == 1, "R1", "tx_ready after reset", tx_ready, 1);
    chk(queue_full == 0, "R1", "queue_full after reset", queue_full, 0);
    chk(!line_pos && !line_neg, "R1", "rails after reset", {line_pos, line_neg}, 0);

    for (int spd = 0; spd < 2; spd++) begin
      for (int mode = 0; mode < 3; mode++) begin
        high_speed = spd[0]; parity_on = (mode != 0); parity_even = (mode == 2);
        pat[0] = 32'h0000_0000; pat[1] = 32'hFFFF_FFFF;
        pat[2] = 32'hA5C3_0F81 ^ (32'(spd) << 7) ^ (32'(mode) << 20);
        pat[3] = 32'h1 << (spd * 13 + mode * 5 + 3);
        tim_err = 0; rail_err = 0;
        base = rx_n;
        for (int i = 0; i < 4; i++) push_word(pat[i]);
        chk(queue_full == 1, "R8", "full after DEPTH writes", queue_full, 1);
        chk(tx_ready == 0, "R10", "ready with words queued", tx_ready, 0);
        @(negedge clk); tx_enable = 1; lat = 0;
        do begin @(negedge clk); lat++; end while (!line_pos && !line_neg && lat < 10);
        chk(lat == 1, "R9", "first bit latency", lat, 1);
        wait_rx(base + 4);
        tx_enable = 0;
        for (int i = 0; i < 4; i++) begin
          if (mode == 0)
            chk(rx[base+i] == pat[i], "R5", "plain word", rx[base+i], pat[i]);
          else if (mode == 1)
            chk(rx[base+i] == expect_word(pat[i], 1, 0), "R6", "odd parity word",
                rx[base+i], expect_word(pat[i], 1, 0));
          else
            chk(rx[base+i] == expect_word(pat[i], 1, 1), "R7", "even parity word",
                rx[base+i], expect_word(pat[i], 1, 1));
        end
        if (spd == 1) begin
          chk(tim_err == 0, "R3", "half-cell length errors", tim_err, 0);
          chk(last_gap == HI_HALF + HI_GAP, "R3", "gap between words", last_gap, HI_HALF + HI_GAP);
        end else begin
          chk(tim_err == 0, "R4", "half-cell length errors", tim_err, 0);
          chk(last_gap == LO_HALF + LO_GAP, "R4", "gap between words", last_gap, LO_HALF + LO_GAP);
        end
        chk(rail_err == 0, "R2", "both rails high", rail_err, 0);
        repeat (half + 2) @(negedge clk);
        chk(tx_ready == 1, "R10", "ready after drain", tx_ready, 1);
      end
    end

    high_speed = 1; parity_on = 0;
    base = rx_n;
    for (int i = 0; i < DEPTH + 2; i++) push_word(32'h100 + 32'(i));
    chk(queue_full == 1, "R8", "full after overflow writes", queue_full, 1);
    tx_enable = 1;
    wait_rx(base + DEPTH);
    repeat (200) @(negedge clk);
    chk(rx_n == base + DEPTH, "R8", "words sent after overflow", rx_n - base, DEPTH);
    for (int i = 0; i < DEPTH; i++)
      chk(rx[base+i] == 32'h100 + 32'(i), "R8", "order after overflow", rx[base+i], 32'h100 + i);
    tx_enable = 0;

    base = rx_n;
    push_word(32'h1357_9BDF); push_word(32'h2468_ACE0);
    tx_enable = 1;
    while (bits < 5) @(negedge clk);
    tx_enable = 0;
    repeat (300) @(negedge clk);
    chk(rx_n == base + 1, "R11", "words after mid-word disable", rx_n - base, 1);
    chk(rx[base] == 32'h1357_9BDF, "R11", "finished word", rx[base], 32'h1357_9BDF);
    chk(tx_ready == 0, "R10", "ready with one word left", tx_ready, 0);
    chk(!line_pos && !line_neg, "R11", "rails idle while disabled", {line_pos, line_neg}, 0);
    tx_enable = 1;
    wait_rx(base + 2);
    chk(rx[base+1] == 32'h2468_ACE0, "R11", "word after re-enable", rx[base+1], 32'h2468_ACE0);
    tx_enable = 0;
    repeat (20) @(negedge clk);

    base = rx_n;
    push_word(32'hDEAD_BEEF); push_word(32'h0BAD_F00D); push_word(32'h7777_0001);
    tx_enable = 1;
    while (!line_pos && !line_neg) @(negedge clk);
    repeat (7) @(negedge clk);
    #3 rst_n = 0;
    #2 chk(!line_pos && !line_neg, "R12", "rails during reset", {line_pos, line_neg}, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_ready == 1, "R12", "queue discarded", tx_ready, 1);
    chk(queue_full == 0, "R12", "full after reset", queue_full, 0);
    repeat (300) @(negedge clk);
    chk(rx_n == base, "R12", "words after reset", rx_n - base, 0);
    tx_enable = 0;
    finish_run();
  end
endmodule